// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This unit adds or subtracts two 32-bit binary floating-point words. Each word has a sign in bit 31, an 8-bit exponent in bits 30:23 stored with a bias of 127, and a 23-bit fraction in bits 22:0 that sits below an implied leading one. The operation passes through a fixed sequence of steps, one step per clock cycle. The operands are unpacked and ordered by magnitude. The smaller significand is aligned to the larger one. The significands are then combined, the result is normalised by its leading-zero count, rounded to nearest-even and packed. A pulse on `start_i` while the unit is idle launches an operation. `done_o` then flags the cycle in which the packed result and the two range flags are valid.

The control is a seven-state machine: `S_IDLE` waits for a start. `S_ALIGN` swaps and shifts the operands. `S_ADD` combines the significands. `S_NORM` applies the leading-zero or carry shift. `S_ROUND` rounds and performs any second right shift. `S_PACK` range-checks and writes the output registers. `S_DONE` presents the result. The transitions are start (`S_IDLE`→`S_ALIGN`), then unconditional steps `S_ALIGN`→`S_ADD`→`S_NORM`→`S_ROUND`→`S_PACK`→`S_DONE`, then retire (`S_DONE`→`S_IDLE`). Only normalised numbers and zero are handled. A word whose exponent field is zero counts as zero. Results outside the normal range are reported on the flags.

Top module: `fpadd_seq`

## Requirements
- R1: A word with exponent field 0 is treated as zero whatever its fraction, so adding or subtracting it leaves the other operand unchanged; the result is packed as sign in bit 31, biased exponent in 30:23, fraction in 22:0.
- R2: With `sub_i`=0 the result is a+b, with `sub_i`=1 it is a-b; magnitudes are added when the sign of a equals the (possibly flipped) sign of b and subtracted otherwise, the result taking the sign of the larger-magnitude operand.
- R3: The operand with the smaller magnitude is shifted right by the exponent difference, with three extra bits below the fraction where everything shifted further is ORed into the lowest (sticky) bit; the result exponent starts at the larger exponent.
- R4: A carry out of the significand sum shifts it right one place and raises the exponent by one; otherwise it is shifted left by its leading-zero count and the exponent lowered by that count.
- R5: Rounding is to nearest, with an exact tie rounded to the value whose fraction LSB is 0.
- R6: When rounding carries out of the significand, it is shifted right once more and the exponent rises by one.
- R7: An exactly zero result is returned as 0x00000000 (positive zero) with both flags low.
- R8: If the final biased exponent exceeds 254, `ovf_o` is 1 and the result saturates to the largest finite value of the result sign (exponent 0xFE, fraction all ones).
- R9: If the final biased exponent is below 1, `unf_o` is 1 and the result is 0x00000000.
- R10: A start accepted in `S_IDLE` makes `busy_o` high from the next cycle; `done_o` is high for exactly one cycle, six cycles after the accepting edge, and `busy_o` falls in the cycle after that.
- R11: `start_i` and the operand inputs are ignored while `busy_o` is high; the running operation's result is unaffected and no extra result follows.
- R12: During and right after reset `busy_o`, `done_o`, `ovf_o`, `unf_o` are 0 and `result_o` is 0x00000000; a reset mid-operation returns to `S_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch an operation (sampled in `S_IDLE`) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| sub_i | input | 1 | 0: add, 1: subtract b from a |
| busy_o | output | 1 | High while an operation is in flight |
| done_o | output | 1 | One-cycle result-valid strobe |
| result_o | output | 32 | Packed result, held until the next operation |
| ovf_o | output | 1 | Exponent overflow on the last result |
| unf_o | output | 1 | Exponent underflow on the last result |

## Verification
Each operation takes a fixed number of cycles, so a state machine that skips, repeats or stalls a step shows at once: `done_o` moves off its six-cycle slot, or never comes, within the same operation. A bad swap decision, a wrong shift distance or a wrong leading-zero count surfaces in that operation's `done_o` cycle as a wrong exponent or fraction. The vectors are chosen so that each such fault changes the packed word: ties, a carry during rounding, sticky-only alignments and exponents at both edges of the normal range.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int GRS_W   = 3;
    localparam int WORK_W  = SIG_W + GRS_W;
    localparam int ACC_W   = WORK_W + 1;
    localparam int EXPS_W  = EXP_W + 2;
    localparam int SH_W    = $clog2(WORK_W + 1);
    localparam int EXP_TOP = (1 << EXP_W) - 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ALIGN,
        S_ADD,
        S_NORM,
        S_ROUND,
        S_PACK,
        S_DONE
    } fpa_state_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
    } fpa_unp_t;
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
    import fpadd_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fpa_unp_t          unp_o
);
    logic [EXP_W-1:0] exp_f;
    assign exp_f = word_i[WORD_W-2 -: EXP_W];

    always_comb begin
        unp_o.sign = word_i[WORD_W-1];
        unp_o.exp  = exp_f;
        unp_o.sig  = (exp_f != '0) ? {1'b1, word_i[FRAC_W-1:0]} : '0;
    end
endmodule

// File: rtl/fpa_rshift_sticky.sv
module fpa_rshift_sticky #(
    parameter int W  = 27,
    parameter int SW = 5
) (
    input  logic [W-1:0]  in_i,
    input  logic [SW-1:0] sh_i,
    output logic [W-1:0]  out_o
);
    logic [W-1:0] moved;
    logic         lost;

    always_comb begin
        moved = in_i >> sh_i;
        lost  = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i < int'(sh_i)) lost = lost | in_i[i];
        end
        out_o = {moved[W-1:1], moved[0] | lost};
    end
endmodule

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
    parameter int W  = 27,
    parameter int CW = 5
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    logic found;

    always_comb begin
        cnt_o = CW'(W);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec_i[i]) begin
                cnt_o = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpadd_seq.sv
module fpadd_seq
    import fpadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              sub_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o,
    output logic              ovf_o,
    output logic              unf_o
);
    localparam logic signed [EXPS_W-1:0] ER_ONE = EXPS_W'(1);
    localparam logic signed [EXPS_W-1:0] ER_MAX = EXPS_W'(EXP_TOP);

    fpa_state_e state_q, state_d;

    // operand capture
    fpa_unp_t ua_w, ub_w, opa_q, opb_q;
    logic     sub_q;

    fpa_unpack u_unp_a (.word_i(a_i), .unp_o(ua_w));
    fpa_unpack u_unp_b (.word_i(b_i), .unp_o(ub_w));

    // swap and align
    logic               a_ge_b, sb_eff, big_sign, eff_sub_w;
    logic [EXP_W-1:0]   big_exp, sml_exp, ediff;
    logic [SIG_W-1:0]   big_sig, sml_sig;
    logic [SH_W-1:0]    sh_w;
    logic [WORK_W-1:0]  sml_shift_w;

    always_comb begin
        a_ge_b    = {opa_q.exp, opa_q.sig} >= {opb_q.exp, opb_q.sig};
        sb_eff    = opb_q.sign ^ sub_q;
        eff_sub_w = opa_q.sign ^ sb_eff;
        big_sign  = a_ge_b ? opa_q.sign : sb_eff;
        big_exp   = a_ge_b ? opa_q.exp  : opb_q.exp;
        big_sig   = a_ge_b ? opa_q.sig  : opb_q.sig;
        sml_exp   = a_ge_b ? opb_q.exp  : opa_q.exp;
        sml_sig   = a_ge_b ? opb_q.sig  : opa_q.sig;
        ediff     = big_exp - sml_exp;
        sh_w      = (ediff > EXP_W'(WORK_W)) ? SH_W'(WORK_W) : ediff[SH_W-1:0];
    end

    fpa_rshift_sticky #(.W(WORK_W), .SW(SH_W)) u_align (
        .in_i  ({sml_sig, {GRS_W{1'b0}}}),
        .sh_i  (sh_w),
        .out_o (sml_shift_w)
    );

    // working registers
    logic [WORK_W-1:0]        big_q, sml_q, norm_q;
    logic [ACC_W-1:0]         acc_q;
    logic [SIG_W-1:0]         mant_q;
    logic signed [EXPS_W-1:0] er_q;
    logic                     sign_q, esub_q, zero_q;

    // normalisation helpers
    logic [SH_W-1:0]   lz_w;
    logic [WORK_W-1:0] shl_w;

    fpa_lzc #(.W(WORK_W), .CW(SH_W)) u_lzc (
        .vec_i (acc_q[WORK_W-1:0]),
        .cnt_o (lz_w)
    );
    assign shl_w = acc_q[WORK_W-1:0] << lz_w;

    // rounding helpers
    logic [SIG_W-1:0] mant_w;
    logic             grd, rnd, stk, up_w;
    logic [SIG_W:0]   m_inc;

    always_comb begin
        mant_w = norm_q[WORK_W-1 -: SIG_W];
        grd    = norm_q[GRS_W-1];
        rnd    = norm_q[GRS_W-2];
        stk    = |norm_q[GRS_W-3:0];
        up_w   = grd & (rnd | stk | mant_w[0]);
        m_inc  = {1'b0, mant_w} + (SIG_W+1)'(up_w);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_ALIGN;
            S_ALIGN: state_d = S_ADD;
            S_ADD:   state_d = S_NORM;
            S_NORM:  state_d = S_ROUND;
            S_ROUND: state_d = S_PACK;
            S_PACK:  state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath steps
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q  <= '0;
            opb_q  <= '0;
            sub_q  <= 1'b0;
            big_q  <= '0;
            sml_q  <= '0;
            acc_q  <= '0;
            norm_q <= '0;
            mant_q <= '0;
            er_q   <= '0;
            sign_q <= 1'b0;
            esub_q <= 1'b0;
            zero_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        opa_q <= ua_w;
                        opb_q <= ub_w;
                        sub_q <= sub_i;
                    end
                end
                S_ALIGN: begin
                    big_q  <= {big_sig, {GRS_W{1'b0}}};
                    sml_q  <= sml_shift_w;
                    sign_q <= big_sign;
                    esub_q <= eff_sub_w;
                    er_q   <= $signed({2'b00, big_exp});
                    zero_q <= 1'b0;
                end
                S_ADD: begin
                    acc_q <= esub_q ? ({1'b0, big_q} - {1'b0, sml_q})
                                    : ({1'b0, big_q} + {1'b0, sml_q});
                end
                S_NORM: begin
                    if (acc_q == '0) begin
                        zero_q <= 1'b1;
                        norm_q <= '0;
                    end else if (acc_q[ACC_W-1]) begin
                        norm_q <= {acc_q[ACC_W-1:2], acc_q[1] | acc_q[0]};
                        er_q   <= er_q + ER_ONE;
                    end else begin
                        norm_q <= shl_w;
                        er_q   <= er_q - $signed({{(EXPS_W-SH_W){1'b0}}, lz_w});
                    end
                end
                S_ROUND: begin
                    if (m_inc[SIG_W]) begin
                        mant_q <= m_inc[SIG_W:1];
                        er_q   <= er_q + ER_ONE;
                    end else begin
                        mant_q <= m_inc[SIG_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            ovf_o    <= 1'b0;
            unf_o    <= 1'b0;
        end else if (state_q == S_PACK) begin
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
            if (zero_q) begin
                result_o <= '0;
            end else if (er_q > ER_MAX) begin
                ovf_o    <= 1'b1;
                result_o <= {sign_q, EXP_W'(EXP_TOP), {FRAC_W{1'b1}}};
            end else if (er_q < ER_ONE) begin
                unf_o    <= 1'b1;
                result_o <= '0;
            end else begin
                result_o <= {sign_q, er_q[EXP_W-1:0], mant_q[FRAC_W-1:0]};
            end
        end
    end

    always_comb begin
        busy_o = (state_q != S_IDLE);
        done_o = (state_q == S_DONE);
    end

    // R4: after a nonzero normalisation the leading significand bit is set
    a_r4_norm_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ROUND && !zero_q) |-> norm_q[WORK_W-1]);

    // R7: no negative zero is ever presented
    a_r7_pos_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o[WORD_W-2:0] == '0) |-> !result_o[WORD_W-1]);

    // R8: overflow saturates to the largest finite magnitude
    a_r8_ovf_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> (result_o[WORD_W-2 -: EXP_W] == EXP_W'(EXP_TOP)
                               && (&result_o[FRAC_W-1:0]) && !unf_o));

    // R9: underflow returns zero
    a_r9_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && unf_o) |-> (result_o == '0));

    // R10: done is a single-cycle strobe and start leads to busy
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !done_o));

    // R11: the captured operands do not move while busy
    a_r11_hold_ops: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(opa_q) && $stable(opb_q)));
endmodule

// File: tb/fpadd_seq_tb.sv
module fpadd_seq_tb;
    import fpadd_pkg::*;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        sub;
        logic [31:0] res;
        logic        ovf;
        logic        unf;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h43802000, 32'h43B2E000, 1'b0, 32'h44198000, 1'b0, 1'b0},
        '{32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0},
        '{32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 1'b0, 1'b0},
        '{32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 1'b0, 1'b0},
        '{32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 1'b0, 1'b0},
        '{32'h3F800000, 32'h40400000, 1'b1, 32'hC0000000, 1'b0, 1'b0},
        '{32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000, 1'b0, 1'b0},
        '{32'h00000000, 32'h40490FDB, 1'b0, 32'h40490FDB, 1'b0, 1'b0},
        '{32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0},
        '{32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0},
        '{32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0},
        '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F7FFFFF, 1'b1, 1'b0},
        '{32'h00800000, 32'h00800001, 1'b1, 32'h00000000, 1'b0, 1'b1},
        '{32'h01000000, 32'h00800000, 1'b1, 32'h00800000, 1'b0, 1'b0},
        '{32'h3F800000, 32'h30800000, 1'b1, 32'h3F800000, 1'b0, 1'b0},
        '{32'hC0400000, 32'h3F800000, 1'b0, 32'hC0000000, 1'b0, 1'b0},
        '{32'h3F800000, 32'h00000001, 1'b1, 32'h3F800000, 1'b0, 1'b0},
        '{32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, 1'b0, 1'b0}
    };
    // 0 R3 spec example, 1 R4 carry, 2-3 R7 exact zero, 4-6 R2 signs,
    // 7 R1 zero operand, 8 R5 tie down, 9 R5 tie up, 10 R6 round carry,
    // 11 R8 overflow, 12 R9 underflow, 13 R4 lowest normal, 14 R3 sticky,
    // 15 R2 negative, 16 R1 zero-exponent word, 17 R4 carry with fraction
    string tags [NV] = '{"R3", "R4", "R7", "R7", "R2", "R2", "R2", "R1", "R5",
                         "R5", "R6", "R8", "R9", "R4", "R3", "R2", "R1", "R4"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sub_i = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        busy_o, done_o, ovf_o, unf_o;
    logic [31:0] result_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fpadd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .sub_i(sub_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input logic s, output int lat);
        @(negedge clk);
        a_i = a; b_i = b; sub_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin : watchdog
        #2000000;
        fails++;
        $display("FAIL R10 watchdog got=hung exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int lat;
        // R12: reset state
        repeat (3) @(negedge clk);
        check("R12 busy", 32'(busy_o), 32'd0);
        check("R12 done", 32'(done_o), 32'd0);
        check("R12 result", result_o, 32'h0);
        check("R12 flags", {30'd0, ovf_o, unf_o}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].a, VECS[i].b, VECS[i].sub, lat);
            check(tags[i], result_o, VECS[i].res);
            check("R8 ovf flag", 32'(ovf_o), 32'(VECS[i].ovf));
            check("R9 unf flag", 32'(unf_o), 32'(VECS[i].unf));
            check("R10 latency", 32'(lat), 32'd6);
            @(negedge clk);
            check("R10 done single", {30'd0, done_o, busy_o}, 32'd0);
        end

        // R11: a second start while busy is ignored
        @(negedge clk);
        a_i = 32'h3F800000; b_i = 32'h3F800000; sub_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R10 busy after start", 32'(busy_o), 32'd1);
        @(negedge clk);
        a_i = 32'h40400000; b_i = 32'h3F800000; sub_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 3;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check("R11 result unaffected", result_o, 32'h40000000);
        check("R11 latency unaffected", 32'(lat), 32'd6);
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done_o) lat++;
        end
        check("R11 no extra done", 32'(lat), 32'd0);

        // R12: reset in the middle of an operation
        @(negedge clk);
        a_i = 32'h7F7FFFFF; b_i = 32'h7F7FFFFF; sub_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 mid reset busy", {30'd0, busy_o, done_o}, 32'd0);
        check("R12 mid reset result", result_o, 32'h0);
        rst_n = 1'b1;
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done_o || busy_o) lat++;
        end
        check("R12 stays idle", 32'(lat), 32'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule